// File: doc/BRIEF.md
# Sensor Register Configuration Sequencer

This block brings an image sensor up from power-on. After the global reset it drives the sensor's system reset for a set number of clocks. It then waits a fixed settle interval. Next it writes a table of twelve configuration words into the sensor. When the last word has been committed, it raises a done flag that lets the shutter controller start. The three phases never overlap, and each one begins only after the one before it has finished.

The words can be delivered in two ways, chosen by a mode input. The first is a 16-bit parallel bus with a write strobe. The second is a three-wire serial link: a shift clock, a data line and a load pulse. The serial link shifts the whole word into the sensor's holding buffer and then commits it with the load pulse. Each word carries the register address in its upper four bits and the 12-bit register value below it. The table is a parameter of the block. Bit 0 of register 0 picks the shutter type, and the block reports that bit once register 0 has been written.

Top module: `sensor_cfg_seq`

## Requirements
- R1: `sensorReset` is high while `rst_n` is low. It stays high for exactly RESET_CYCLES rising clock edges after `rst_n` is released, and it does not rise again until the next `rst_n` assertion.
- R2: After `sensorReset` falls, SETTLE_CYCLES clocks pass with `parStrobe`, `serClk` and `serLoad` all low. The first write activity is visible RESET_CYCLES+SETTLE_CYCLES+1 edges after release.
- R3: Exactly twelve words are committed, to registers 0 to 11 in ascending order. Each word has the register address in bits 15:12 and the table entry for that register in bits 11:0.
- R4: In parallel mode each word takes three clocks. `parData` shows the word one clock before `parStrobe`, `parStrobe` is high for one clock, and `parData` holds the same word for one clock after the strobe.
- R5: In serial mode each word takes 33 clocks. The block gives 16 rising edges of `serClk` with the bits most significant first, each bit set up on `serData` while `serClk` is low and held while it is high. It then gives a single-clock `serLoad` pulse with `serClk` low.
- R6: `modeSerial` (1 = serial, 0 = parallel) is sampled on the clock at which the write phase begins. Later changes have no effect until the next `rst_n`. The interface that is not selected stays at zero on all its outputs.
- R7: `cfgDone` goes high on the clock after the twelfth word's last cycle. It stays high until `rst_n` is asserted and is never high together with `sensorReset`.
- R8: `shutterRolling` is 0 until register 0 has been written. After that it equals bit 0 of register 0's value (1 = rolling, 0 = synchronous), and it stays that way until `rst_n` is asserted.
- R9: Asserting `rst_n` at any point aborts the sequence. After release, the block runs again from the reset phase and writes all twelve words once more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Global active-low asynchronous reset |
| modeSerial | input | 1 | Interface select: 1 serial three-wire, 0 parallel |
| sensorReset | output | 1 | Sensor system reset, active high |
| parData | output | 16 | Parallel configuration word |
| parStrobe | output | 1 | Parallel write strobe |
| serClk | output | 1 | Serial shift clock |
| serData | output | 1 | Serial data, MSB first |
| serLoad | output | 1 | Serial commit pulse |
| cfgDone | output | 1 | Configuration complete, shutter controller may start |
| shutterRolling | output | 1 | Shutter type from register 0 bit 0 once written |

## Verification
The assertions take three things as given. First, `rst_n` is the only input that can restart the sequence. Second, `modeSerial` is only required to be stable around the clock at which the write phase begins. Third, the sensor consumes each word within the cycles the block gives it, because the block has no backpressure input.

The stimulus keeps to these assumptions. It sets the mode before releasing reset and holds it until the write phase has begun. From that point it toggles the mode at random, to show that the toggles are ignored. The bench also aborts one sequence part-way with `rst_n` and then runs it again.

// File: rtl/sensor_cfg_pkg.sv
package sensor_cfg_pkg;

  typedef enum logic [1:0] {
    SEQ_RESET  = 2'd0,
    SEQ_SETTLE = 2'd1,
    SEQ_WRITE  = 2'd2,
    SEQ_DONE   = 2'd3
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic waitRun;     // advance the wait counter
    logic waitClr;     // clear the wait counter
    logic waitSettle;  // compare against the settle length
    logic beginWrite;  // latch mode, clear word index and step
    logic drive;       // write phase active
    logic nextWord;    // current word finished
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic waitDone;
    logic wordEnd;
    logic lastWord;
  } dpStatus_t;

endpackage

// File: rtl/cfg_ctrl.sv
module cfg_ctrl
  import sensor_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        sensorReset,
  output logic        cfgDone
);

  seqState_e state, stateNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEQ_RESET;
    else        state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      SEQ_RESET: begin
        strobe.waitRun = 1'b1;
        if (status.waitDone) begin
          strobe.waitClr = 1'b1;
          stateNext      = SEQ_SETTLE;
        end
      end
      SEQ_SETTLE: begin
        strobe.waitRun    = 1'b1;
        strobe.waitSettle = 1'b1;
        if (status.waitDone) begin
          strobe.waitClr    = 1'b1;
          strobe.beginWrite = 1'b1;
          stateNext         = SEQ_WRITE;
        end
      end
      SEQ_WRITE: begin
        strobe.drive = 1'b1;
        if (status.wordEnd) begin
          strobe.nextWord = 1'b1;
          if (status.lastWord) stateNext = SEQ_DONE;
        end
      end
      SEQ_DONE: stateNext = SEQ_DONE;
      default:  stateNext = SEQ_RESET;
    endcase
  end

  assign sensorReset = (state == SEQ_RESET);
  assign cfgDone     = (state == SEQ_DONE);

endmodule

// File: rtl/cfg_dpath.sv
module cfg_dpath
  import sensor_cfg_pkg::*;
#(
  parameter int NUM_REGS      = 12,
  parameter int WORD_W        = 16,
  parameter int VAL_W         = 12,
  parameter int RESET_CYCLES  = 64,
  parameter int SETTLE_CYCLES = 16,
  parameter logic [NUM_REGS*VAL_W-1:0] CFG_VALUES = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              modeSerial,
  input  ctrlStrobe_t       strobe,
  output dpStatus_t         status,
  output logic [WORD_W-1:0] parData,
  output logic              parStrobe,
  output logic              serClk,
  output logic              serData,
  output logic              serLoad,
  output logic              shutterRolling
);

  localparam int ADDR_W    = WORD_W - VAL_W;
  localparam int IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int WAIT_MAX  = (RESET_CYCLES > SETTLE_CYCLES) ? RESET_CYCLES : SETTLE_CYCLES;
  localparam int WAIT_W    = $clog2(WAIT_MAX + 1);
  localparam int PAR_STEPS = 3;
  localparam int SER_STEPS = 2 * WORD_W + 1;
  localparam int STEP_W    = $clog2(SER_STEPS + 1);

  // configuration table unpacked from the parameter
  logic [VAL_W-1:0] tableMem [NUM_REGS];
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_table
    assign tableMem[g] = CFG_VALUES[g*VAL_W +: VAL_W];
  end

  logic [WAIT_W-1:0] waitCnt;
  logic [STEP_W-1:0] stepCnt;
  logic [IDX_W-1:0]  wordIdx;
  logic              serMode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              waitCnt <= '0;
    else if (strobe.waitClr) waitCnt <= '0;
    else if (strobe.waitRun) waitCnt <= waitCnt + 1'b1;
  end

  assign status.waitDone = strobe.waitSettle
                         ? (waitCnt == WAIT_W'(SETTLE_CYCLES - 1))
                         : (waitCnt == WAIT_W'(RESET_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stepCnt        <= '0;
      wordIdx        <= '0;
      serMode        <= 1'b0;
      shutterRolling <= 1'b0;
    end else if (strobe.beginWrite) begin
      stepCnt <= '0;
      wordIdx <= '0;
      serMode <= modeSerial;
    end else if (strobe.nextWord) begin
      stepCnt <= '0;
      wordIdx <= wordIdx + 1'b1;
      if (wordIdx == '0) shutterRolling <= tableMem[0][0];
    end else if (strobe.drive) begin
      stepCnt <= stepCnt + 1'b1;
    end
  end

  assign status.wordEnd  = stepCnt == (serMode ? STEP_W'(SER_STEPS - 1)
                                               : STEP_W'(PAR_STEPS - 1));
  assign status.lastWord = (wordIdx == IDX_W'(NUM_REGS - 1));

  // word under transmission: address on top, value below
  logic [WORD_W-1:0]   curWord;
  logic [WORD_W-1:0]   shiftedWord;
  logic [STEP_W-2:0]   bitPos;
  logic                serShifting;

  assign curWord     = {ADDR_W'(wordIdx), tableMem[wordIdx]};
  assign bitPos      = stepCnt[STEP_W-1:1];
  assign shiftedWord = curWord << bitPos;
  assign serShifting = strobe.drive && serMode && (stepCnt < STEP_W'(2 * WORD_W));

  assign parData   = (strobe.drive && !serMode) ? curWord : '0;
  assign parStrobe = strobe.drive && !serMode && (stepCnt == STEP_W'(1));
  assign serClk    = serShifting && stepCnt[0];
  assign serData   = serShifting && shiftedWord[WORD_W-1];
  assign serLoad   = strobe.drive && serMode && (stepCnt == STEP_W'(2 * WORD_W));

endmodule

// File: rtl/sensor_cfg_seq.sv
module sensor_cfg_seq
  import sensor_cfg_pkg::*;
#(
  parameter int NUM_REGS      = 12,
  parameter int WORD_W        = 16,
  parameter int VAL_W         = 12,
  parameter int RESET_CYCLES  = 64,
  parameter int SETTLE_CYCLES = 16,
  parameter logic [NUM_REGS*VAL_W-1:0] CFG_VALUES =
    144'h0FF_123_456_789_ABC_DEF_010_200_3A5_07F_400_001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              modeSerial,
  output logic              sensorReset,
  output logic [WORD_W-1:0] parData,
  output logic              parStrobe,
  output logic              serClk,
  output logic              serData,
  output logic              serLoad,
  output logic              cfgDone,
  output logic              shutterRolling
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  cfg_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .status      (status),
    .strobe      (strobe),
    .sensorReset (sensorReset),
    .cfgDone     (cfgDone)
  );

  cfg_dpath #(
    .NUM_REGS      (NUM_REGS),
    .WORD_W        (WORD_W),
    .VAL_W         (VAL_W),
    .RESET_CYCLES  (RESET_CYCLES),
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .CFG_VALUES    (CFG_VALUES)
  ) u_dpath (
    .clk            (clk),
    .rst_n          (rst_n),
    .modeSerial     (modeSerial),
    .strobe         (strobe),
    .status         (status),
    .parData        (parData),
    .parStrobe      (parStrobe),
    .serClk         (serClk),
    .serData        (serData),
    .serLoad        (serLoad),
    .shutterRolling (shutterRolling)
  );

endmodule

// File: rtl/sensor_cfg_seq_chk.sv
module sensor_cfg_seq_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sensorReset,
  input logic [WORD_W-1:0] parData,
  input logic              parStrobe,
  input logic              serClk,
  input logic              serLoad,
  input logic              cfgDone,
  input logic              shutterRolling
);

  // R1
  rst_stays_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sensorReset |=> !sensorReset);

  // R2
  quiet_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sensorReset |-> (!parStrobe && !serClk && !serLoad));

  // R4
  par_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    parStrobe |-> $stable(parData));

  // R4
  par_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    parStrobe |=> ($stable(parData) && !parStrobe));

  // R5
  load_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    serLoad |-> !serClk);

  // R6
  one_iface_chk: assert property (@(posedge clk) disable iff (!rst_n)
    parStrobe |-> (!serClk && !serLoad));

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfgDone |=> cfgDone);

  // R7
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfgDone && sensorReset));

  // R8
  shutter_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutterRolling |=> shutterRolling);

endmodule

bind sensor_cfg_seq sensor_cfg_seq_chk #(.WORD_W(WORD_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .sensorReset    (sensorReset),
  .parData        (parData),
  .parStrobe      (parStrobe),
  .serClk         (serClk),
  .serLoad        (serLoad),
  .cfgDone        (cfgDone),
  .shutterRolling (shutterRolling)
);

// File: tb/sensor_cfg_seq_tb.sv
module sensor_cfg_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NREG   = 12;
  localparam int VW     = 12;
  localparam int WW     = 16;
  localparam int RST_CY = 6;
  localparam int SET_CY = 4;
  localparam logic [NREG*VW-1:0] TABLE =
    144'h5A5_F00_0F0_00F_123_321_ABC_CBA_777_888_999_0C1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          modeSerial = 1'b0;
  logic          sensorReset, parStrobe, serClk, serData, serLoad, cfgDone, shutterRolling;
  logic [WW-1:0] parData;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sensor_cfg_seq #(
    .NUM_REGS(NREG), .WORD_W(WW), .VAL_W(VW),
    .RESET_CYCLES(RST_CY), .SETTLE_CYCLES(SET_CY), .CFG_VALUES(TABLE)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .modeSerial(modeSerial),
    .sensorReset(sensorReset), .parData(parData), .parStrobe(parStrobe),
    .serClk(serClk), .serData(serData), .serLoad(serLoad),
    .cfgDone(cfgDone), .shutterRolling(shutterRolling)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int expWord(input int idx);
    return (idx << VW) | int'(TABLE[idx*VW +: VW]);
  endfunction

  // model state
  int commits;
  int firstAct;
  logic prevSerClk;
  logic [WW-1:0] prevPar;
  logic [WW-1:0] shiftBuf;
  int bitCnt;
  bit pendPar;
  logic [WW-1:0] pendData;

  task automatic commitWord(input logic [WW-1:0] w);
    // R3
    check(w == WW'(expWord(commits)), "R3", "committed word", int'(w), expWord(commits));
    commits++;
  endtask

  task automatic runSeq(input bit mode, input bit toggle, input int abortAt);
    int base, limit;
    rst_n = 1'b0;
    modeSerial = mode;
    repeat (3) @(negedge clk);
    // R1 R7 R8 reset state
    check(sensorReset == 1'b1, "R1", "reset held during rst_n", int'(sensorReset), 1);
    check(!cfgDone && !shutterRolling, "R7", "done/shutter in reset", int'(cfgDone), 0);
    check(!parStrobe && !serClk && !serLoad, "R2", "no writes in reset",
          int'({parStrobe, serClk, serLoad}), 0);
    commits = 0; firstAct = -1; prevSerClk = 1'b0; prevPar = '0;
    shiftBuf = '0; bitCnt = 0; pendPar = 1'b0; pendData = '0;
    base  = RST_CY + SET_CY;
    limit = base + NREG * (mode ? 33 : 3) + 6;
    rst_n = 1'b1;
    for (int j = 1; j <= limit; j++) begin
      @(negedge clk);
      if (abortAt > 0 && j == abortAt) return;
      // R1 exact reset length
      check(sensorReset == (j < RST_CY), "R1", "sensorReset level", int'(sensorReset),
            int'(j < RST_CY));
      // R7 done timing (model commits before this sample)
      check(cfgDone == (commits == NREG), "R7", "cfgDone level", int'(cfgDone),
            int'(commits == NREG));
      // R8 shutter type
      check(shutterRolling == ((commits > 0) ? TABLE[0] : 1'b0), "R8", "shutterRolling",
            int'(shutterRolling), int'((commits > 0) ? TABLE[0] : 1'b0));
      if (parStrobe || serClk || serLoad) begin
        // R2 no activity before settle ends
        if (firstAct < 0) begin
          firstAct = j;
          check(j == base + 1, "R2", "first write cycle", j, base + 1);
        end
      end
      // R6 unused interface idle
      if (mode)
        check(!parStrobe && parData == '0, "R6", "parallel idle in serial mode",
              int'(parData), 0);
      else
        check(!serClk && !serLoad && !serData, "R6", "serial idle in parallel mode",
              int'({serClk, serLoad, serData}), 0);
      // parallel model, R4
      if (pendPar) begin
        check(parData == pendData, "R4", "data held after strobe", int'(parData), int'(pendData));
        commitWord(pendData);
        pendPar = 1'b0;
      end
      if (parStrobe) begin
        check(parData == prevPar, "R4", "data set up before strobe", int'(parData), int'(prevPar));
        check(j == base + 1 + 3 * commits, "R4", "strobe cycle", j, base + 1 + 3 * commits);
        pendPar = 1'b1;
        pendData = parData;
      end
      // serial model, R5
      if (serClk && !prevSerClk) begin
        shiftBuf = {shiftBuf[WW-2:0], serData};
        bitCnt++;
      end
      if (serLoad) begin
        check(bitCnt == WW, "R5", "bits before load", bitCnt, WW);
        check(j == base + 32 + 33 * commits, "R5", "load cycle", j, base + 32 + 33 * commits);
        commitWord(shiftBuf);
        bitCnt = 0;
      end
      prevSerClk = serClk;
      prevPar = parData;
      // R6 mode changes after write start are ignored
      if (toggle && j >= base) modeSerial = 1'($urandom_range(0, 1));
    end
    // R3 R7 sequence complete
    check(commits == NREG, "R3", "words committed", commits, NREG);
    check(cfgDone == 1'b1, "R7", "done after sequence", int'(cfgDone), 1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    void'($urandom(32'd2024));
    runSeq(1'b0, 1'b0, 0);            // parallel, directed
    runSeq(1'b1, 1'b0, 0);            // serial, directed
    runSeq(1'b1, 1'b0, RST_CY + SET_CY + 50); // R9 abort mid-word
    runSeq(1'b1, 1'b0, 0);            // R9 full rerun after abort
    runSeq(1'b0, 1'b0, RST_CY + 2);   // R9 abort in settle
    runSeq(1'b0, 1'b1, 0);            // R9 rerun, with mode toggling
    for (int k = 0; k < 4; k++)
      runSeq(1'($urandom_range(0, 1)), 1'b1, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule